// File: doc/BRIEF.md
# Angle Word Host Port with Freeze and Byte Lanes

This block is the host-facing digital port of a tracking angle converter. It receives the converter's internal angle word and a busy flag that marks each counter update. It keeps the word in a holding register, which follows the counter while the host lets it run. The holding register never takes the word while an update is in progress.

The host freezes the holding register with an active-low hold request. The tracking counter keeps running during the freeze, and the freeze may last for any length of time. The host reads the frozen word through two byte lanes. Each lane has its own active-low enable. A lane with its enable inactive is modelled as a zero data bus with its output-enable flag low.

A coarse/fine resolution select is taken only when a busy pulse ends, so it can never race a counter step. In coarse mode the two least significant bits on the low lane read as zero. The hold request and both lane enables arrive asynchronously and pass through two-flop synchronizers.

Top module: `angle_host_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both lane output-enables are 0, both lanes read 0x00, the held word is 0 and the port is in fine (16-bit) mode.
- R2: While busy is low and no freeze is active, the held word equals the counter word sampled at the previous clock edge.
- R3: While busy is high the held word does not change; the first clock edge with busy low loads the counter word.
- R4: The hold request hold_n is synchronized by two flops. A freeze takes effect at the second edge after hold_n goes low. The port then makes exactly one more load at the next edge with busy low, and afterwards holds that word whatever the counter does, including during busy pulses.
- R5: If a freeze takes effect while busy is high, the held word is the counter word present at the first edge after busy falls, and it is held from then on.
- R6: When hold_n returns high, the held word stays frozen through the second edge and follows the counter again from the third edge.
- R7: res_coarse (1 = coarse 14-bit, 0 = fine 16-bit) is stored only at the clock edge where busy was high on the previous edge and is low now; changes at any other time have no effect on the lanes.
- R8: The high lane carries held-word bits [15:8] and the low lane carries bits [7:0]. In coarse mode, low-lane bits [1:0] read 0.
- R9: Each lane enable (hi_en_n, lo_en_n, active low) is synchronized by two flops. Its output-enable rises at the second edge after the enable goes low. While the output-enable is 0, that lane's data reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_word | input | 16 | Angle word from the tracking counter |
| cnt_busy | input | 1 | High while the counter is updating |
| hold_n | input | 1 | Asynchronous active-low freeze request |
| res_coarse | input | 1 | Resolution select, 1 = 14-bit, 0 = 16-bit |
| hi_en_n | input | 1 | Asynchronous active-low high-lane enable |
| lo_en_n | input | 1 | Asynchronous active-low low-lane enable |
| hi_lane | output | 8 | High byte of held word, 0 when disabled |
| hi_lane_oe | output | 1 | High-lane drive enable |
| lo_lane | output | 8 | Low byte of held word, masked in coarse mode, 0 when disabled |
| lo_lane_oe | output | 1 | Low-lane drive enable |

## Verification
The assertions check on every cycle the rules that hold between adjacent cycles. The held word stays still during busy and during a locked freeze, it follows the counter when the port runs free, the resolution flag moves only on a busy falling edge, and a disabled or coarse-mode lane shows no stray bits. The bench scenarios are needed for everything that depends on synchronizer latency. That covers the exact edge at which a freeze or release takes hold, the single final load after a freeze, a freeze begun inside a busy pulse, and the rise of each output-enable.

// File: rtl/angle_port_pkg.sv
// Package: shared widths and helpers for the angle host port.
// Assumes a 16-bit angle word split into two 8-bit lanes.
package angle_port_pkg;
    localparam int WORD_W   = 16;
    localparam int LANE_W   = 8;
    localparam int COARSE_W = 14;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/ap_sync.sv
// Module: multi-bit, multi-stage synchronizer for asynchronous control inputs.
// Assumes each bit is independent (no bus coherence required).
module ap_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each bit one stage deeper into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d_async;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ap_busy_track.sv
// Module: detects the end of each busy pulse and stores the resolution
// select there. Assumes busy is already in the clock domain.
module ap_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic res_sel,
    output logic coarse_q
);
    logic busy_q;
    logic busy_end;

    // Remember the previous busy level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    assign busy_end = busy_q && !busy;

    // Take the resolution select only on a busy trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        coarse_q <= 1'b0;
        else if (busy_end) coarse_q <= res_sel;
    end

    // R7: the mode flag moves only on a busy trailing edge
    p_res_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && !busy) |=> $stable(coarse_q));
endmodule

// File: rtl/ap_hold_latch.sv
// Module: holding register for the angle word. Follows the counter while
// not frozen and not busy; on freeze, makes one final non-busy load and locks.
// Assumes freeze is already synchronized.
module ap_hold_latch #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cnt,
    input  logic             busy,
    input  logic             freeze,
    output logic [WIDTH-1:0] word_q
);
    logic locked_q;
    logic load;

    assign load = !busy && (!freeze || !locked_q);

    // Load the counter word when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= cnt;
    end

    // Lock after the final load of a freeze; unlock on release.
    always_ff @(posedge clk) begin
        if (!rst_n || !freeze) locked_q <= 1'b0;
        else if (load)         locked_q <= 1'b1;
    end

    // R3: no change across a busy cycle
    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_q));
    // R4: a locked freeze keeps the word
    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && locked_q) |=> $stable(word_q));
    // R2: free-running tracking of the counter
    p_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !freeze) |=> (word_q == $past(cnt)));
endmodule

// File: rtl/ap_lane_drive.sv
// Module: one byte lane. Presents its slice of the held word when enabled,
// zero otherwise; optionally clears low bits in coarse mode.
module ap_lane_drive #(
    parameter int LANE_W    = 8,
    parameter int DROP_BITS = 0
) (
    input  logic [LANE_W-1:0] slice,
    input  logic              coarse,
    input  logic              oe,
    output logic [LANE_W-1:0] lane
);
    logic [LANE_W-1:0] shown;

    generate
        if (DROP_BITS > 0) begin : g_mask
            localparam logic [LANE_W-1:0] KEEP = ~((LANE_W'(1) << DROP_BITS) - LANE_W'(1));
            // Clear the unused fine bits in coarse mode.
            always_comb shown = coarse ? (slice & KEEP) : slice;
        end else begin : g_pass
            // Full lane, no masking.
            always_comb shown = slice;
        end
    endgenerate

    // Gate data with the drive enable.
    always_comb lane = oe ? shown : '0;
endmodule

// File: rtl/angle_host_port.sv
// Module: top of the angle host port. Synchronizes host controls, holds the
// angle word under a freeze, tracks resolution on busy end, drives lanes.
// Assumes cnt_word and cnt_busy are in the clk domain.
module angle_host_port
    import angle_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cnt_word,
    input  logic              cnt_busy,
    input  logic              hold_n,
    input  logic              res_coarse,
    input  logic              hi_en_n,
    input  logic              lo_en_n,
    output logic [LANE_W-1:0] hi_lane,
    output logic              hi_lane_oe,
    output logic [LANE_W-1:0] lo_lane,
    output logic              lo_lane_oe
);
    localparam int DROP = WORD_W - COARSE_W;

    logic [2:0] ctl_sync;
    word_t      word_q;
    logic       coarse_q;
    logic       freeze;

    ap_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({hold_n, hi_en_n, lo_en_n}),
        .q_sync(ctl_sync)
    );

    assign freeze     = !ctl_sync[2];
    assign hi_lane_oe = !ctl_sync[1];
    assign lo_lane_oe = !ctl_sync[0];

    ap_busy_track u_busy (
        .clk(clk), .rst_n(rst_n), .busy(cnt_busy),
        .res_sel(res_coarse), .coarse_q(coarse_q)
    );

    ap_hold_latch #(.WIDTH(WORD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_word), .busy(cnt_busy),
        .freeze(freeze), .word_q(word_q)
    );

    ap_lane_drive #(.LANE_W(LANE_W), .DROP_BITS(0)) u_hi (
        .slice(word_q[WORD_W-1 -: LANE_W]), .coarse(coarse_q),
        .oe(hi_lane_oe), .lane(hi_lane)
    );

    ap_lane_drive #(.LANE_W(LANE_W), .DROP_BITS(DROP)) u_lo (
        .slice(word_q[LANE_W-1:0]), .coarse(coarse_q),
        .oe(lo_lane_oe), .lane(lo_lane)
    );

    // R8: coarse mode shows no fine bits on the low lane
    p_coarse_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_q |-> (lo_lane[DROP-1:0] == '0));
    // R9: disabled lanes read zero
    p_lane_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_lane_oe |-> hi_lane == '0) and (!lo_lane_oe |-> lo_lane == '0));
endmodule

// File: tb/angle_host_port_tb.sv
module angle_host_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_word = '0;
    logic        cnt_busy = 1'b0;
    logic        hold_n = 1'b1;
    logic        res_coarse = 1'b0;
    logic        hi_en_n = 1'b1;
    logic        lo_en_n = 1'b1;
    logic [7:0]  hi_lane, lo_lane;
    logic        hi_lane_oe, lo_lane_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    angle_host_port u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_word(cnt_word), .cnt_busy(cnt_busy),
        .hold_n(hold_n), .res_coarse(res_coarse), .hi_en_n(hi_en_n),
        .lo_en_n(lo_en_n), .hi_lane(hi_lane), .hi_lane_oe(hi_lane_oe),
        .lo_lane(lo_lane), .lo_lane_oe(lo_lane_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [15:0] exp);
        chk(req, {hi_lane, lo_lane}, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; tick(3);
        chk("R1 oe", {14'd0, hi_lane_oe, lo_lane_oe}, 16'h0000);
        chk_word("R1 lanes", 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_enable;
        hi_en_n = 1'b0; lo_en_n = 1'b0; tick(1);
        chk("R9 oe after one edge", {15'd0, hi_lane_oe}, 16'h0000);
        tick(1);
        chk("R9 oe after two edges", {14'd0, hi_lane_oe, lo_lane_oe}, 16'h0003);
        chk_word("R1 word zero", 16'h0000);
    endtask

    task automatic t_track;
        cnt_word = 16'hA5C3; tick(1);
        chk_word("R2 R8 track", 16'hA5C3);
        cnt_word = 16'h5A3C; tick(1);
        chk_word("R2 track second", 16'h5A3C);
    endtask

    task automatic t_busy;
        cnt_busy = 1'b1; cnt_word = 16'h1234; tick(3);
        chk_word("R3 hold in busy", 16'h5A3C);
        cnt_busy = 1'b0; tick(1);
        chk_word("R3 load after busy", 16'h1234);
    endtask

    task automatic t_freeze;
        hold_n = 1'b0; cnt_word = 16'h4321; tick(3);
        chk_word("R4 final load", 16'h4321);
        cnt_word = 16'h9999; tick(3);
        chk_word("R4 frozen", 16'h4321);
        cnt_busy = 1'b1; cnt_word = 16'h7777; tick(2);
        cnt_busy = 1'b0; tick(2);
        chk_word("R4 frozen across busy", 16'h4321);
        cnt_word = 16'h9999;
        hold_n = 1'b1; tick(2);
        chk_word("R6 still frozen", 16'h4321);
        tick(1);
        chk_word("R6 follows again", 16'h9999);
    endtask

    task automatic t_freeze_in_busy;
        cnt_busy = 1'b1; cnt_word = 16'h0F0F; hold_n = 1'b0; tick(4);
        chk_word("R5 busy holds old", 16'h9999);
        cnt_busy = 1'b0; tick(1);
        chk_word("R5 load after busy", 16'h0F0F);
        cnt_word = 16'hFFFF; tick(3);
        chk_word("R5 held", 16'h0F0F);
        hold_n = 1'b1; tick(3);
        chk_word("R6 release", 16'hFFFF);
    endtask

    task automatic t_resolution;
        res_coarse = 1'b1; cnt_word = 16'hABCF; tick(3);
        chk_word("R7 ignored while idle", 16'hABCF);
        cnt_busy = 1'b1; tick(2);
        cnt_busy = 1'b0; tick(2);
        chk_word("R7 R8 coarse mask", 16'hABCC);
        res_coarse = 1'b0; tick(3);
        chk_word("R7 ignored change", 16'hABCC);
        cnt_busy = 1'b1; tick(2);
        cnt_busy = 1'b0; tick(2);
        chk_word("R7 back to fine", 16'hABCF);
    endtask

    task automatic t_disable;
        hi_en_n = 1'b1; tick(3);
        chk("R9 hi off", {15'd0, hi_lane_oe}, 16'h0000);
        chk_word("R9 hi zero lo live", 16'h00CF);
        lo_en_n = 1'b1; tick(3);
        chk_word("R9 both zero", 16'h0000);
    endtask

    initial begin
        tick(1);
        t_reset;
        t_enable;
        t_track;
        t_busy;
        t_freeze;
        t_freeze_in_busy;
        t_resolution;
        t_disable;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired got 0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule